// File: doc/BRIEF.md
# Supply and Fault Event Status Register

This block holds one byte of sticky event flags gathered from thermal, supply-monitor, memory-fault and channel-shutdown logic. Each flag is set by a one-cycle pulse or a held level on its event input and stays set until the host takes it away. A host reaches the byte through a small command port. One command code only looks at the byte. A second code returns the same byte and then empties the register. A masked OR of the flags drives a registered interrupt request.

Two resets act on the flags. The power-on reset loads a fixed start value. The pin reset leaves the four supply and thermal flags as they were and clears only the two low flags.

The shutdown-event flag has two detection modes for a group of four channels. In the first mode it follows a shutdown pin, qualified by per-channel enables. In the second mode it compares a received 3-bit priority code against a priority set for each channel.

The block also produces a power-on permit for the channel controller. This permit is withheld while the power-rail undervoltage flag is set, unless the rail is reported above its restart level.

Top module: `supply_event_status`

## Requirements
- R1: When `cmd_valid` is high at a clock edge, code 0x0A returns the byte and leaves it unchanged, and code 0x0B returns the byte and clears it. `rd_valid` is high for exactly the following cycle with the byte on `rd_data`. Any other code gives no response and changes nothing.
- R2: The byte layout is: bit 7 thermal shutdown, bit 6 logic-supply lockout, bit 5 logic-supply warning, bit 4 power-rail undervoltage, bit 1 shutdown event, bit 0 memory fault, all active high. Bits 3 and 2 always read 0.
- R3: After power-on reset (`por_n` low at a clock edge) the byte reads 0x70. `rd_valid` and `irq` are 0 while reset is held.
- R4: A pin reset (`pin_rst_n` low at a clock edge, `por_n` high) keeps bits 7 to 4 at their previous values and clears bits 1 and 0.
- R5: A clear command leaves bit 6 set, if it was set, for as long as `vpwr_uv_active` is high. Once that input is low, the next clear empties bit 6.
- R6: With `sd_mode` = 0, bit 1 sets when `sd_pin` is high while at least one bit of `sd_enable` is high. A high `sd_pin` with `sd_enable` = 0 has no effect.
- R7: With `sd_mode` = 1, bit 1 sets when `sd_code_valid` is high and `sd_code` is greater than or equal to the priority of any channel. Channel n takes its priority from `ch_prio[3n+2:3n]`. A code with `sd_code_valid` low has no effect.
- R8: `pwon_permit` is low while bit 4 is set and `vpwr_above_30v` is low. In every other case it is high.
- R9: `irq` equals the OR of (byte AND `irq_mask`) as it stood one cycle earlier. It therefore rises one cycle after a masked bit sets and falls one cycle after a clear removes the last masked bit.
- R10: An event input that is active in the same cycle as a clear command wins. Its bit is set after the clear.
- R11: The byte returned by a clear command is the value from before the clear.
- R12: A set bit stays set after its event input returns low, until a clear or a reset removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous active-low power-on reset |
| pin_rst_n | input | 1 | Synchronous active-low external pin reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code (0x0A look, 0x0B take) |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted command |
| rd_data | output | 8 | Returned status byte |
| evt_thermal | input | 1 | Thermal shutdown event |
| evt_vdd_uvlo | input | 1 | Logic-supply lockout event |
| evt_vdd_warn | input | 1 | Logic-supply warning event |
| evt_vpwr_uv | input | 1 | Power-rail undervoltage event |
| evt_sram_fault | input | 1 | Memory fault event |
| vpwr_uv_active | input | 1 | Power-rail undervoltage still present |
| vpwr_above_30v | input | 1 | Power rail above restart level |
| sd_mode | input | 1 | 0 = pin mode, 1 = priority-code mode |
| sd_pin | input | 1 | Shutdown pin level |
| sd_enable | input | 4 | Per-channel shutdown enable (pin mode) |
| sd_code_valid | input | 1 | Priority code strobe |
| sd_code | input | 3 | Received priority code |
| ch_prio | input | 12 | Per-channel priority, 3 bits per channel |
| irq_mask | input | 8 | Interrupt mask per status bit |
| irq | output | 1 | Registered interrupt request |
| pwon_permit | output | 1 | Channel power-on allowed |

## Verification
The hardest case to reach is a clear command that lands in the same clock edge as a new event, or while the power-rail undervoltage condition holds bit 6. Here the result depends on the order of clear and set inside one update. The bench drives the event input and the 0x0B command on the same falling edge, so both are sampled at one rising edge. It then checks two things: the returned byte is the old one, and a following look command shows the new bit. For the bit 6 hold, `vpwr_uv_active` stays high across a clear and is then released before a second clear.

// File: rtl/ses_pkg.sv
// Shared constants for the supply event status register.
// Assumes an 8-bit status byte with fixed bit positions decoded by the host.
package ses_pkg;
    localparam int STAT_W = 8;
    localparam int CMD_W  = 8;

    localparam logic [CMD_W-1:0] CMD_LOOK = 8'h0A;
    localparam logic [CMD_W-1:0] CMD_TAKE = 8'h0B;

    localparam int B_THERM = 7;
    localparam int B_VUVLO = 6;
    localparam int B_VWARN = 5;
    localparam int B_PRAIL = 4;
    localparam int B_SDEVT = 1;
    localparam int B_MFLT  = 0;

    localparam logic [STAT_W-1:0] POR_VALUE  = 8'h70;
    localparam logic [STAT_W-1:0] KEEP_MASK  = 8'hF0;
    localparam logic [STAT_W-1:0] LIVE_MASK  = 8'hF3;

    typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/ses_shutdown_detect.sv
// Shutdown-event detector for a group of channels.
// Pin mode: pin high with any channel enabled. Code mode: a valid code at or
// above any channel's priority. Output is combinational; the caller registers it.
module ses_shutdown_detect #(
    parameter int NUM_CH = 4,
    parameter int PRIO_W = 3
) (
    input  logic                     mode_code,
    input  logic                     pin_lvl,
    input  logic [NUM_CH-1:0]        ch_en,
    input  logic                     code_vld,
    input  logic [PRIO_W-1:0]        code,
    input  logic [NUM_CH*PRIO_W-1:0] prio_flat,
    output logic                     hit
);
    logic [NUM_CH-1:0] at_or_above;

    // Per-channel comparison of the received code against its priority.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
        assign at_or_above[ch] = (code >= prio_flat[ch*PRIO_W +: PRIO_W]);
    end

    // Select the detection rule for the active mode.
    always_comb begin
        if (mode_code) hit = code_vld && (|at_or_above);
        else           hit = pin_lvl && (|ch_en);
    end
endmodule

// File: rtl/ses_status_bits.sv
// Sticky status byte with two reset domains.
// Power-on reset loads POR_VALUE; pin reset keeps KEEP_MASK bits and zeroes
// the rest. A clear empties the byte except held bits; same-cycle sets win.
module ses_status_bits
    import ses_pkg::*;
(
    input  logic  clk,
    input  logic  por_n,
    input  logic  pin_rst_n,
    input  stat_t set_vec,
    input  logic  clr,
    input  stat_t hold_vec,
    output stat_t bits
);
    stat_t bits_q;
    stat_t after_clr;

    // Bits that survive a clear: only those already set and requested to hold.
    assign after_clr = clr ? (bits_q & hold_vec) : bits_q;

    // Status register update with power-on, pin-reset and clear handling.
    always_ff @(posedge clk) begin
        if (!por_n)          bits_q <= POR_VALUE;
        else if (!pin_rst_n) bits_q <= bits_q & KEEP_MASK;
        else                 bits_q <= (after_clr | set_vec) & LIVE_MASK;
    end

    assign bits = bits_q;

    a_r4_pin_keep: assert property (@(posedge clk) disable iff (!por_n)
        (por_n && !pin_rst_n) |=> (bits_q[7:4] == $past(bits_q[7:4]) && bits_q[1:0] == 2'b00));

    a_r12_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (por_n && pin_rst_n && !clr) |=> ((bits_q & $past(bits_q)) == $past(bits_q)));

    a_r5_uvlo_hold: assert property (@(posedge clk) disable iff (!por_n)
        (por_n && pin_rst_n && hold_vec[B_VUVLO] && bits_q[B_VUVLO]) |=> bits_q[B_VUVLO]);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!por_n)
        (por_n && pin_rst_n && clr && set_vec[B_THERM]) |=> bits_q[B_THERM]);
endmodule

// File: rtl/ses_read_port.sv
// Command decoder and read-data capture.
// Assumes one command per strobe; data is captured at the accepting edge so
// the returned byte predates any clear issued by the same command.
module ses_read_port
    import ses_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  stat_t            cur_bits,
    output logic             take_clr,
    output logic             rd_valid,
    output stat_t            rd_data
);
    logic is_look;
    logic is_take;

    // Decode the two supported codes.
    assign is_look  = cmd_valid && (cmd_code == CMD_LOOK);
    assign is_take  = cmd_valid && (cmd_code == CMD_TAKE);
    assign take_clr = is_take;

    // Capture the byte and raise valid for one cycle per accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= is_look || is_take;
            if (is_look || is_take) rd_data <= cur_bits;
        end
    end

    a_r1_valid_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(cmd_valid));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[3:2] == 2'b00));
endmodule

// File: rtl/ses_irq.sv
// Registered interrupt request from the masked status byte.
// Output follows the masked OR one cycle late.
module ses_irq
    import ses_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  stat_t bits,
    input  stat_t mask,
    output logic  irq
);
    // Register the reduction so the request is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(bits & mask);
    end
endmodule

// File: rtl/supply_event_status.sv
// Supply and fault event status register top.
// Collects event inputs into a sticky byte, serves host look/take commands,
// drives a masked interrupt and gates channel power-on during rail undervoltage.
module supply_event_status
    import ses_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int PRIO_W = 3
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     pin_rst_n,
    input  logic                     cmd_valid,
    input  logic [7:0]               cmd_code,
    output logic                     rd_valid,
    output logic [7:0]               rd_data,
    input  logic                     evt_thermal,
    input  logic                     evt_vdd_uvlo,
    input  logic                     evt_vdd_warn,
    input  logic                     evt_vpwr_uv,
    input  logic                     evt_sram_fault,
    input  logic                     vpwr_uv_active,
    input  logic                     vpwr_above_30v,
    input  logic                     sd_mode,
    input  logic                     sd_pin,
    input  logic [NUM_CH-1:0]        sd_enable,
    input  logic                     sd_code_valid,
    input  logic [PRIO_W-1:0]        sd_code,
    input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
    input  logic [7:0]               irq_mask,
    output logic                     irq,
    output logic                     pwon_permit
);
    logic  rst_n;
    logic  sd_hit;
    logic  take_clr;
    stat_t set_vec;
    stat_t hold_vec;
    stat_t status;

    assign rst_n = por_n && pin_rst_n;

    // Shutdown event detection for the channel group.
    ses_shutdown_detect #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_sd (
        .mode_code (sd_mode),
        .pin_lvl   (sd_pin),
        .ch_en     (sd_enable),
        .code_vld  (sd_code_valid),
        .code      (sd_code),
        .prio_flat (ch_prio),
        .hit       (sd_hit)
    );

    // Map event inputs onto their status positions.
    always_comb begin
        set_vec          = '0;
        set_vec[B_THERM] = evt_thermal;
        set_vec[B_VUVLO] = evt_vdd_uvlo;
        set_vec[B_VWARN] = evt_vdd_warn;
        set_vec[B_PRAIL] = evt_vpwr_uv;
        set_vec[B_SDEVT] = sd_hit;
        set_vec[B_MFLT]  = evt_sram_fault;
    end

    // Lockout bit survives a clear while the rail undervoltage persists.
    always_comb begin
        hold_vec          = '0;
        hold_vec[B_VUVLO] = vpwr_uv_active;
    end

    ses_status_bits u_bits (
        .clk       (clk),
        .por_n     (por_n),
        .pin_rst_n (pin_rst_n),
        .set_vec   (set_vec),
        .clr       (take_clr),
        .hold_vec  (hold_vec),
        .bits      (status)
    );

    ses_read_port u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cur_bits  (status),
        .take_clr  (take_clr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    ses_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .bits  (status),
        .mask  (irq_mask),
        .irq   (irq)
    );

    // Power-on gate: blocked while the rail flag is set below restart level.
    assign pwon_permit = !status[B_PRAIL] || vpwr_above_30v;

    a_r8_pwon_gate: assert property (@(posedge clk) disable iff (!por_n)
        (status[B_PRAIL] && !vpwr_above_30v) |-> !pwon_permit);

    a_r9_irq_follow: assert property (@(posedge clk) disable iff (!por_n)
        (por_n && pin_rst_n) |=> (irq == $past(|(status & irq_mask))));

    a_r11_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && take_clr) |=> (rd_data == $past(status)));
endmodule

// File: tb/supply_event_status_tb_top.sv
module supply_event_status_tb_top;
    logic        clk = 1'b0;
    logic        por_n, pin_rst_n;
    logic        cmd_valid;
    logic [7:0]  cmd_code;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        evt_thermal, evt_vdd_uvlo, evt_vdd_warn, evt_vpwr_uv, evt_sram_fault;
    logic        vpwr_uv_active, vpwr_above_30v;
    logic        sd_mode, sd_pin, sd_code_valid;
    logic [3:0]  sd_enable;
    logic [2:0]  sd_code;
    logic [11:0] ch_prio;
    logic [7:0]  irq_mask;
    logic        irq, pwon_permit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    supply_event_status dut_i (
        .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .evt_thermal(evt_thermal), .evt_vdd_uvlo(evt_vdd_uvlo),
        .evt_vdd_warn(evt_vdd_warn), .evt_vpwr_uv(evt_vpwr_uv),
        .evt_sram_fault(evt_sram_fault),
        .vpwr_uv_active(vpwr_uv_active), .vpwr_above_30v(vpwr_above_30v),
        .sd_mode(sd_mode), .sd_pin(sd_pin), .sd_enable(sd_enable),
        .sd_code_valid(sd_code_valid), .sd_code(sd_code), .ch_prio(ch_prio),
        .irq_mask(irq_mask), .irq(irq), .pwon_permit(pwon_permit)
    );

    // Vector: {expect_valid, event byte, command code, expected byte}
    localparam int NVEC = 9;
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 8'h00, 8'h0A, 8'h70},
        {1'b1, 8'h00, 8'h0B, 8'h70},
        {1'b1, 8'h00, 8'h0A, 8'h00},
        {1'b1, 8'h80, 8'h0A, 8'h80},
        {1'b1, 8'h01, 8'h0B, 8'h81},
        {1'b1, 8'h20, 8'h0A, 8'h20},
        {1'b0, 8'h00, 8'h0C, 8'h00},
        {1'b1, 8'h00, 8'h0B, 8'h20},
        {1'b1, 8'h00, 8'h0A, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_events(input logic [7:0] ev);
        evt_thermal    = ev[7];
        evt_vdd_uvlo   = ev[6];
        evt_vdd_warn   = ev[5];
        evt_vpwr_uv    = ev[4];
        evt_sram_fault = ev[0];
    endtask

    // Hold events for one rising edge, then drop them.
    task automatic pulse(input logic [7:0] ev);
        set_events(ev);
        @(negedge clk);
        set_events(8'h00);
    endtask

    // Issue one command; return outputs sampled after the accepting edge.
    task automatic cmd(input logic [7:0] code, output logic v, output logic [7:0] d);
        cmd_valid = 1'b1;
        cmd_code  = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        v = rd_valid;
        d = rd_data;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic       v;
        logic [7:0] d;
        por_n = 1'b0; pin_rst_n = 1'b1;
        cmd_valid = 1'b0; cmd_code = 8'h00;
        set_events(8'h00);
        vpwr_uv_active = 1'b0; vpwr_above_30v = 1'b0;
        sd_mode = 1'b0; sd_pin = 1'b0; sd_enable = 4'h0;
        sd_code_valid = 1'b0; sd_code = 3'd0;
        ch_prio = {3'd7, 3'd6, 3'd5, 3'd4};
        irq_mask = 8'h00;
        repeat (3) @(negedge clk);
        // R3: outputs in reset; R8: rail flag set from power-on blocks power-on
        chk("R3 rd_valid in reset", {7'd0, rd_valid}, 8'h00);
        chk("R3 irq in reset", {7'd0, irq}, 8'h00);
        chk("R8 permit blocked after power-on", {7'd0, pwon_permit}, 8'h00);
        vpwr_above_30v = 1'b1;
        #1;
        chk("R8 permit with rail above restart", {7'd0, pwon_permit}, 8'h01);
        vpwr_above_30v = 1'b0;
        por_n = 1'b1;
        @(negedge clk);

        // Table walk: R1 look/take/unknown, R2 layout, R3 start value, R11, R12
        for (int i = 0; i < NVEC; i++) begin
            pulse(VEC[i][23:16]);
            cmd(VEC[i][15:8], v, d);
            chk($sformatf("R1 valid vec %0d", i), {7'd0, v}, {7'd0, VEC[i][24]});
            if (VEC[i][24]) chk($sformatf("R2 R11 data vec %0d", i), d, VEC[i][7:0]);
        end

        // R8: rail flag cleared, permit independent of restart input
        chk("R8 permit after clear", {7'd0, pwon_permit}, 8'h01);

        // R12: bit stays after input drops for several cycles
        pulse(8'h80);
        repeat (3) @(negedge clk);
        cmd(8'h0B, v, d);
        chk("R12 sticky thermal", d, 8'h80);

        // R10: event and take in the same cycle
        evt_thermal = 1'b1;
        cmd(8'h0B, v, d);
        evt_thermal = 1'b0;
        chk("R10 R11 take returns old byte", d, 8'h00);
        cmd(8'h0A, v, d);
        chk("R10 event survives clear", d, 8'h80);
        cmd(8'h0B, v, d);

        // R5: lockout held while rail undervoltage persists
        vpwr_uv_active = 1'b1;
        pulse(8'h40);
        cmd(8'h0B, v, d);
        chk("R5 take while held", d, 8'h40);
        cmd(8'h0A, v, d);
        chk("R5 lockout still set", d, 8'h40);
        vpwr_uv_active = 1'b0;
        cmd(8'h0B, v, d);
        cmd(8'h0A, v, d);
        chk("R5 lockout cleared after release", d, 8'h00);

        // R6: pin mode
        sd_pin = 1'b1; sd_enable = 4'h0;
        @(negedge clk);
        sd_pin = 1'b0;
        cmd(8'h0A, v, d);
        chk("R6 pin with no enable ignored", d, 8'h00);
        sd_pin = 1'b1; sd_enable = 4'b0100;
        @(negedge clk);
        sd_pin = 1'b0; sd_enable = 4'h0;
        cmd(8'h0B, v, d);
        chk("R6 pin with enable sets bit 1", d, 8'h02);

        // R7: code mode with priorities 4,5,6,7 on channels 0..3
        sd_mode = 1'b1;
        sd_pin = 1'b1; sd_enable = 4'hF;
        sd_code_valid = 1'b1; sd_code = 3'd3;
        @(negedge clk);
        sd_code_valid = 1'b0; sd_code = 3'd7;
        @(negedge clk);
        sd_pin = 1'b0; sd_enable = 4'h0;
        cmd(8'h0A, v, d);
        chk("R7 low or unstrobed code ignored", d, 8'h00);
        sd_code_valid = 1'b1; sd_code = 3'd4;
        @(negedge clk);
        sd_code_valid = 1'b0;
        cmd(8'h0B, v, d);
        chk("R7 code at channel priority sets bit 1", d, 8'h02);
        sd_mode = 1'b0;

        // R9: registered interrupt rise and fall
        irq_mask = 8'h80;
        pulse(8'h20);
        @(negedge clk);
        chk("R9 unmasked bit gives no irq", {7'd0, irq}, 8'h00);
        pulse(8'h80);
        chk("R9 irq one cycle after bit", {7'd0, irq}, 8'h00);
        @(negedge clk);
        chk("R9 irq raised", {7'd0, irq}, 8'h01);
        cmd(8'h0B, v, d);
        chk("R9 irq held at clear edge", {7'd0, irq}, 8'h01);
        @(negedge clk);
        chk("R9 irq released after clear", {7'd0, irq}, 8'h00);
        irq_mask = 8'h00;

        // R4: pin reset keeps upper bits, clears lower
        pulse(8'hA1);
        sd_pin = 1'b1; sd_enable = 4'h1;
        @(negedge clk);
        sd_pin = 1'b0; sd_enable = 4'h0;
        cmd(8'h0A, v, d);
        chk("R4 before pin reset", d, 8'hA3);
        pin_rst_n = 1'b0;
        @(negedge clk);
        pin_rst_n = 1'b1;
        cmd(8'h0A, v, d);
        chk("R4 after pin reset", d, 8'hA0);

        // R3: power-on reset reloads start value
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        cmd(8'h0A, v, d);
        chk("R3 power-on value", d, 8'h70);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule